// File: doc/BRIEF.md
# Flash Status Polling Completion Checker

This block runs on the host side after a program or erase command has been sent to a parallel NOR flash. It decides whether that operation passed or failed. A one-cycle start pulse loads the address to watch and the value that bit 7 of the status word should show once the operation is over. The block then keeps issuing single-word reads over a request/acknowledge bus to that one address. Each returned word is judged only on its bit 7 and its bit 5.

A read whose bit 7 equals the expected value ends the run with a pass. A read with the wrong bit 7 and bit 5 clear starts another read. When bit 5 is set, the block does not give up straight away. Bit 7 may flip in the same read that raises bit 5, so the block makes one extra read and lets that read's bit 7 settle the outcome. A configurable poll limit guarantees that the block stops even if bit 5 never rises. At the end, done pulses for one cycle while pass and limit show the outcome.

Top module: `dpoll_ctrl`

## Requirements
- R1: After reset the block is idle: rd_req_o, done_o, busy_o, pass_o and limit_o are all 0.
- R2: A start_i pulse while idle loads addr_i and exp_d7_i and sets busy_o. A start_i while busy_o is high has no effect on the address read, on the expected value or on the outcome.
- R3: Every read request goes out on rd_addr_o with the loaded address. rd_req_o stays high, with rd_addr_o unchanged, until the cycle in which rd_ack_i is high.
- R4: rd_data_i is taken only in a cycle where both rd_req_o and rd_ack_i are high. Its value in any other cycle has no effect.
- R5: A read whose bit 7 equals the expected value ends the run with pass_o=1. done_o is high for exactly one cycle. pass_o and limit_o keep their values while idle until the next accepted start.
- R6: A read whose bit 7 differs from the expected value and whose bit 5 is 0 leads to another read of the same address.
- R7: A read whose bit 7 differs and whose bit 5 is 1 leads to exactly one more read. That read ends the run: pass_o=1 if its bit 7 matches, otherwise pass_o=0. limit_o stays 0 in both cases.
- R8: After MAX_POLLS reads with a wrong bit 7 and bit 5 clear, the run ends with pass_o=0 and limit_o=1, and no further read is made.
- R9: If the read that reaches the limit has bit 5 set, the extra read of R7 is still made, and its outcome decides the run.
- R10: An accepted start clears pass_o and limit_o in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a polling run (one-cycle pulse) |
| exp_d7_i | input | 1 | Expected bit 7 value when the operation is complete |
| addr_i | input | AW | Address to poll |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge; rd_data_i is valid in this cycle |
| rd_data_i | input | DW | Read data word |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| pass_o | output | 1 | Outcome: 1 = pass |
| limit_o | output | 1 | Run ended because the poll limit was reached |

## Verification
Two decisions can fall on the same read: bit 7 turning correct in the very read that raises bit 5, and bit 5 rising on the read that uses up the last allowed poll. The bench scripts status words for both cases. It sends one mismatching word with bit 5 set, followed by a matching word. It also sends a run of mismatches whose final allowed word carries bit 5. In each case the outcome must come from the extra read, never from bit 5 or from the limit. The bench judges the total read count as well as pass and limit, so a missing or duplicated extra read shows up.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_REREAD,
    ST_RECHECK,
    ST_DONE
  } dpoll_state_e;
endpackage

// File: rtl/dpoll_cnt.sv
module dpoll_cnt #(
  parameter int MAX_POLLS = 1024,
  localparam int CW = $clog2(MAX_POLLS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_max_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i && !at_max_o) cnt_q <= cnt_q + 1'b1;
  end

  assign at_max_o = (cnt_q == CW'(MAX_POLLS));

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_POLLS)); // R8
endmodule

// File: rtl/dpoll_eval.sv
module dpoll_eval #(
  parameter int DW       = 16,
  parameter int STAT_BIT = 7,
  parameter int TMO_BIT  = 5
) (
  input  logic [DW-1:0] word_i,
  input  logic          exp_i,
  output logic          match_o,
  output logic          tmo_o
);
  assign match_o = (word_i[STAT_BIT] == exp_i);
  assign tmo_o   = word_i[TMO_BIT];
endmodule

// File: rtl/dpoll_ctrl.sv
module dpoll_ctrl
  import dpoll_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int MAX_POLLS = 1024,
  parameter int STAT_BIT  = 7,
  parameter int TMO_BIT   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          exp_d7_i,
  input  logic [AW-1:0] addr_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          limit_o
);
  dpoll_state_e  state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] word_q;
  logic          exp_q, pass_q, limit_q;
  logic          match, tmo, at_max, accept, take;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign take   = rd_req_o && rd_ack_i;

  dpoll_eval #(.DW(DW), .STAT_BIT(STAT_BIT), .TMO_BIT(TMO_BIT)) u_eval (
    .word_i (word_q),
    .exp_i  (exp_q),
    .match_o(match),
    .tmo_o  (tmo)
  );

  dpoll_cnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .inc_i   ((state_q == ST_READ) && rd_ack_i),
    .at_max_o(at_max)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_READ;
      ST_READ:    if (rd_ack_i) state_d = ST_CHECK;
      ST_CHECK: begin
        if (match)       state_d = ST_DONE;
        else if (tmo)    state_d = ST_REREAD;   // mandatory re-read wins over limit
        else if (at_max) state_d = ST_DONE;
        else             state_d = ST_READ;
      end
      ST_REREAD:  if (rd_ack_i) state_d = ST_RECHECK;
      ST_RECHECK: state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      exp_q   <= 1'b0;
      word_q  <= '0;
      pass_q  <= 1'b0;
      limit_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= addr_i;
        exp_q   <= exp_d7_i;
        pass_q  <= 1'b0;
        limit_q <= 1'b0;
      end
      if (take) word_q <= rd_data_i;
      if (state_q == ST_CHECK) begin
        if (match)               pass_q  <= 1'b1;
        else if (!tmo && at_max) limit_q <= 1'b1;
      end
      if (state_q == ST_RECHECK) pass_q <= match;
    end
  end

  assign rd_req_o  = (state_q == ST_READ) || (state_q == ST_REREAD);
  assign rd_addr_o = addr_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign pass_o    = pass_q;
  assign limit_o   = limit_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> $stable(rd_addr_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(pass_o) && $stable(limit_o)); // R5
  AST_LIMIT_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_o |-> !pass_o); // R8
  AST_BUSY_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> $stable(rd_addr_o)); // R2
endmodule

// File: tb/sim_dpoll_ctrl.sv
module sim_dpoll_ctrl;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int MAXP = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          exp_d7_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_ack_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic          busy_o, done_o, pass_o, limit_o;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] scr [16];
  logic [DW-1:0] idle_word = '0;
  logic [AW-1:0] want_addr = '0;
  int idx = 0;
  int lat = 0;
  int wait_c = 0;
  int addr_bad = 0;

  always #2 clk_i = ~clk_i;

  dpoll_ctrl #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) u0 (
    .clk_i, .rst_ni, .start_i, .exp_d7_i, .addr_i,
    .rd_req_o, .rd_addr_o, .rd_ack_i, .rd_data_i,
    .busy_o, .done_o, .pass_o, .limit_o
  );

  // bus responder: acks after lat idle cycles, feeds decoy data otherwise
  always @(negedge clk_i) begin
    if (rd_req_o && !rd_ack_i && wait_c >= lat) begin
      rd_ack_i  <= 1'b1;
      rd_data_i <= scr[idx];
      if (rd_addr_o !== want_addr) addr_bad = addr_bad + 1;
      idx = idx + 1;
      wait_c = 0;
    end else begin
      rd_ack_i  <= 1'b0;
      rd_data_i <= idle_word;
      if (rd_req_o && !rd_ack_i) wait_c = wait_c + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] wd(input bit d7, input bit d5, input logic [DW-1:0] fill);
    logic [DW-1:0] w;
    w = fill;
    w[7] = d7;
    w[5] = d5;
    return w;
  endfunction

  task automatic launch(input bit e, input logic [AW-1:0] a, input int l);
    idx = 0; wait_c = 0; addr_bad = 0; lat = l;
    want_addr = a;
    idle_word = wd(e, 1'b0, 16'h0000);
    @(negedge clk_i);
    start_i = 1'b1; exp_d7_i = e; addr_i = a;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(pass_o == 1'b0 && limit_o == 1'b0, "R10", int'({pass_o, limit_o}), 0);
    chk(busy_o == 1'b1, "R2", int'(busy_o), 1);
  endtask

  task automatic finish_run(input string req, input bit p, input bit lim, input int reads);
    int n = 0;
    while (!done_o && n < 300) begin @(negedge clk_i); n++; end
    chk(done_o == 1'b1, req, int'(done_o), 1);
    chk(pass_o == p, req, int'(pass_o), int'(p));
    chk(limit_o == lim, req, int'(limit_o), int'(lim));
    chk(idx == reads, req, idx, reads);
    chk(addr_bad == 0, "R3", addr_bad, 0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R5", int'(done_o), 0);
    repeat (3) @(negedge clk_i);
    chk(pass_o == p && limit_o == lim && !rd_req_o, "R5", int'({pass_o, limit_o}), int'({p, lim}));
  endtask

  task automatic t_reset();
    chk(!rd_req_o && !done_o && !busy_o && !pass_o && !limit_o, "R1",
        int'({rd_req_o, done_o, busy_o, pass_o, limit_o}), 0);
  endtask

  task automatic t_first_pass();
    scr[0] = wd(1'b1, 1'b0, 16'h5A40);
    launch(1'b1, 24'h001234, 0);
    finish_run("R5", 1'b1, 1'b0, 1);
  endtask

  task automatic t_poll_then_pass();
    // decoy words match while ack is low: only acked data may count (R4)
    for (int i = 0; i < 3; i++) scr[i] = wd(1'b0, 1'b0, 16'hFF5F);
    scr[3] = wd(1'b1, 1'b0, 16'h0000);
    launch(1'b1, 24'h0ABCDE, 3);
    finish_run("R6", 1'b1, 1'b0, 4);
  endtask

  task automatic t_tmo_reread_pass();
    scr[0] = wd(1'b1, 1'b1, 16'h00A0);
    scr[1] = wd(1'b0, 1'b1, 16'h0020);
    launch(1'b0, 24'h100000, 1);
    finish_run("R7", 1'b1, 1'b0, 2);
  endtask

  task automatic t_tmo_reread_fail();
    scr[0] = wd(1'b0, 1'b1, 16'h1234);
    scr[1] = wd(1'b0, 1'b1, 16'h4321);
    launch(1'b1, 24'h200000, 0);
    finish_run("R7", 1'b0, 1'b0, 2);
  endtask

  task automatic t_limit();
    for (int i = 0; i < MAXP; i++) scr[i] = wd(1'b0, 1'b0, 16'h0F0F);
    scr[MAXP] = wd(1'b1, 1'b0, 16'h0000);
    launch(1'b1, 24'h300004, 0);
    finish_run("R8", 1'b0, 1'b1, MAXP);
  endtask

  task automatic t_limit_with_tmo();
    for (int i = 0; i < MAXP - 1; i++) scr[i] = wd(1'b1, 1'b0, 16'h0000);
    scr[MAXP-1] = wd(1'b1, 1'b1, 16'h0000);
    scr[MAXP]   = wd(1'b0, 1'b1, 16'h0000);
    launch(1'b0, 24'h400008, 0);
    finish_run("R9", 1'b1, 1'b0, MAXP + 1);
  endtask

  task automatic t_start_busy();
    scr[0] = wd(1'b0, 1'b0, 16'h0000);
    scr[1] = wd(1'b1, 1'b0, 16'h0000);
    launch(1'b1, 24'h500010, 4);
    @(negedge clk_i);
    start_i = 1'b1; exp_d7_i = 1'b0; addr_i = 24'h7FFFFF;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(rd_addr_o == 24'h500010, "R2", int'(rd_addr_o), 24'h500010);
    finish_run("R2", 1'b1, 1'b0, 2);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_first_pass();
    t_poll_then_pass();
    t_tmo_reread_pass();
    t_tmo_reread_fail();
    t_limit();
    t_limit_with_tmo();
    t_start_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule